// File: doc/BRIEF.md
# Program Memory Checksum Accumulator

This block forms the 16-bit checksum of a device image as the words stream past. A host pulses `start` and presents the configuration word and the four identification words in the same cycle. It then feeds program words one per cycle, qualified by `word_valid`, and flags the final word with `last`. One cycle after that final word the block pulses `done` and presents the checksum, along with a flag that says whether the number of words received matched the expected array size.

The protection setting decides what the sum is made of. It is read from the configuration word captured at `start`. When protection is off, the result is every streamed program word plus the configuration word masked with 0x21FF. When protection is on, the program words are left out. In their place the block adds a 16-bit value packed from the low nibble of each identification word. All arithmetic wraps at 16 bits.

Top module: `cks_accumulator`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `count_err` are 0 and `checksum` is 0x0000 until the first run completes.
- R2: With protection off (configuration bit 13 equal to 1 at `start`), the checksum equals the sum of every accepted program word, zero-extended to 16 bits, plus (configuration word AND 0x21FF).
- R3: With protection on (configuration bit 13 equal to 0 at `start`), the checksum equals (configuration word AND 0x21FF) plus the packed ID value, and the program words have no effect on it.
- R4: The packed ID value is {ID0[3:0], ID1[3:0], ID2[3:0], ID3[3:0]}, where ID0 occupies `id_words[13:0]`, ID1 `id_words[27:14]`, ID2 `id_words[41:28]` and ID3 `id_words[55:42]`. Bits 13..4 of every ID word are ignored.
- R5: Every addition wraps modulo 2^16 and carries out of bit 15 are discarded. A blank 1024-word image (all words 0x3FFF, configuration 0x3FFF) yields 0x1DFF.
- R6: `done` is a one-cycle pulse in the cycle after the accepted beat that carries `last`. `checksum` changes only in that cycle and holds its value otherwise.
- R7: `count_err` is updated together with `done`. It is 1 when the number of accepted beats in the run, including the last one, differs from NUM_WORDS, and 0 when it matches.
- R8: `start` clears the running sum and the beat count and captures the protection decision, the masked configuration word and the ID value. Changes on `cfg_word` or `id_words` after that cycle do not affect the run. A second `start` in mid-run restarts the run from zero.
- R9: A beat is accepted only while `busy` is 1, `word_valid` is 1 and `start` is 0. Beats outside a run, or in the `start` cycle, change neither the sum nor the count, and never raise `done`.
- R10: `busy` rises in the cycle after `start` and falls in the same cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run; captures configuration and ID words |
| cfg_word | input | WORD_W (14) | Configuration word, sampled at `start` |
| id_words | input | NUM_IDS*WORD_W (56) | Four ID words, ID0 in the lowest slice, sampled at `start` |
| word_valid | input | 1 | Qualifies `word_data` as a program word |
| word_data | input | WORD_W (14) | Program word |
| last | input | 1 | Marks the final program word of the run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| checksum | output | 16 | Final checksum, held until the next result |
| count_err | output | 1 | Word count did not match NUM_WORDS |

## Verification
The bench builds the block with its defaults: a 1024-word array, 14-bit words, four ID words, and protection active when bit 13 is low. That size makes the blank-image constant 0x1DFF directly observable, so the wrap-around of the sum is exercised by real data rather than by contrived values. With 1024 words, runs that end one beat short or one beat long are also cheap. This brings the count mismatch into reach from both sides, along with mid-run restarts, idle-time beats and configuration changes after `start`.

// File: rtl/cks_pkg.sv
package cks_pkg;

   localparam int unsigned CKS_W    = 16;
   localparam int unsigned ID_NIB_W = 4;
   localparam logic [CKS_W-1:0] CFG_KEEP_MASK = 16'h21FF;

   typedef struct packed {
      logic             protect;
      logic [CKS_W-1:0] cfg_term;
      logic [CKS_W-1:0] id_term;
   } cks_setup_t;

endpackage

// File: rtl/cks_id_pack.sv
module cks_id_pack #(
   parameter int unsigned WORD_W  = 14,
   parameter int unsigned NUM_IDS = 4,
   parameter int unsigned NIB_W   = 4
) (
   input  logic [NUM_IDS*WORD_W-1:0] id_words,
   output logic [NUM_IDS*NIB_W-1:0]  id_packed
);

   localparam int unsigned HI_W = WORD_W - NIB_W;

   generate
      if (WORD_W <= NIB_W) begin : g_bad_width
         $error("cks_id_pack: WORD_W must exceed NIB_W");
      end
   endgenerate

   logic [NUM_IDS*HI_W-1:0] unused_id_hi;

   generate
      for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
         // first ID lands in the most significant nibble
         assign id_packed[(NUM_IDS-1-g)*NIB_W +: NIB_W] = id_words[g*WORD_W +: NIB_W];
         assign unused_id_hi[g*HI_W +: HI_W]           = id_words[g*WORD_W+NIB_W +: HI_W];
      end
   endgenerate

endmodule

// File: rtl/cks_beat_counter.sv
module cks_beat_counter #(
   parameter int unsigned NUM_WORDS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic hit_target
);

   localparam int unsigned CNT_W = $clog2(NUM_WORDS) + 1;
   localparam logic [CNT_W-1:0] CNT_SAT     = '1;
   localparam logic [CNT_W-1:0] CNT_LAST_IX = CNT_W'(NUM_WORDS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != CNT_SAT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // true while the beat now arriving is the NUM_WORDS-th one
   assign hit_target = (cnt_q == CNT_LAST_IX);

endmodule

// File: rtl/cks_accum.sv
module cks_accum #(
   parameter int unsigned WORD_W = 14,
   parameter int unsigned SUM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              add_en,
   input  logic [WORD_W-1:0] word,
   output logic [SUM_W-1:0]  acc_next
);

   generate
      if (WORD_W > SUM_W) begin : g_bad_width
         $error("cks_accum: WORD_W must not exceed SUM_W");
      end
   endgenerate

   logic [SUM_W-1:0] acc_q;

   assign acc_next = acc_q + (add_en ? SUM_W'(word) : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else begin
         acc_q <= acc_next;
      end
   end

endmodule

// File: rtl/cks_accumulator.sv
module cks_accumulator
   import cks_pkg::*;
#(
   parameter int unsigned NUM_WORDS       = 1024,
   parameter int unsigned WORD_W          = 14,
   parameter int unsigned NUM_IDS         = 4,
   parameter int unsigned PROT_BIT        = 13,
   parameter bit          PROT_ACTIVE_LOW = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [WORD_W-1:0]         cfg_word,
   input  logic [NUM_IDS*WORD_W-1:0] id_words,
   input  logic                      word_valid,
   input  logic [WORD_W-1:0]         word_data,
   input  logic                      last,
   output logic                      busy,
   output logic                      done,
   output logic [CKS_W-1:0]          checksum,
   output logic                      count_err
);

   generate
      if (!(NUM_WORDS == 1024 || NUM_WORDS == 2048 || NUM_WORDS == 4096)) begin : g_bad_depth
         $error("cks_accumulator: NUM_WORDS must be 1024, 2048 or 4096");
      end
      if (NUM_IDS * ID_NIB_W != CKS_W) begin : g_bad_ids
         $error("cks_accumulator: packed ID value must fill the checksum width");
      end
      if (PROT_BIT >= WORD_W) begin : g_bad_bit
         $error("cks_accumulator: PROT_BIT outside configuration word");
      end
   endgenerate

   logic             prot_raw;
   logic [CKS_W-1:0] id_packed;
   cks_setup_t       setup_d, setup_q;
   logic             busy_q, done_q, err_q;
   logic [CKS_W-1:0] cks_q;
   logic             beat, fin, hit_target;
   logic [CKS_W-1:0] acc_next, sum_final;

   generate
      if (PROT_ACTIVE_LOW) begin : g_prot_low
         assign prot_raw = ~cfg_word[PROT_BIT];
      end else begin : g_prot_high
         assign prot_raw = cfg_word[PROT_BIT];
      end
   endgenerate

   cks_id_pack #(
      .WORD_W  (WORD_W),
      .NUM_IDS (NUM_IDS),
      .NIB_W   (ID_NIB_W)
   ) u_id_pack (
      .id_words  (id_words),
      .id_packed (id_packed)
   );

   always_comb begin
      setup_d.protect  = prot_raw;
      setup_d.cfg_term = CKS_W'(cfg_word) & CFG_KEEP_MASK;
      setup_d.id_term  = id_packed;
   end

   assign beat = busy_q && word_valid && !start;
   assign fin  = beat && last;

   cks_accum #(
      .WORD_W (WORD_W),
      .SUM_W  (CKS_W)
   ) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .add_en   (beat && !setup_q.protect),
      .word     (word_data),
      .acc_next (acc_next)
   );

   cks_beat_counter #(
      .NUM_WORDS (NUM_WORDS)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .inc        (beat),
      .hit_target (hit_target)
   );

   assign sum_final = (setup_q.protect ? setup_q.id_term : acc_next) + setup_q.cfg_term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         setup_q <= '0;
         done_q  <= 1'b0;
         cks_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         done_q <= fin;
         if (start) begin
            busy_q  <= 1'b1;
            setup_q <= setup_d;
         end else if (fin) begin
            busy_q <= 1'b0;
         end
         if (fin) begin
            cks_q <= sum_final;
            err_q <= !hit_target;
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign checksum  = cks_q;
   assign count_err = err_q;

endmodule

// File: rtl/cks_accumulator_checker.sv
module cks_accumulator_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        word_valid,
   input logic        last,
   input logic        busy,
   input logic        done,
   input logic [15:0] checksum,
   input logic        count_err
);

   assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && word_valid && last && !start) |=> (done && !busy));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_cks_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(checksum));

   assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(count_err));

   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !done);

endmodule

bind cks_accumulator cks_accumulator_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .word_valid (word_valid),
   .last       (last),
   .busy       (busy),
   .done       (done),
   .checksum   (checksum),
   .count_err  (count_err)
);

// File: tb/cks_accumulator_bench.sv
module cks_accumulator_bench;

   localparam int N = 1024;
   localparam int W = 14;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [W-1:0]  cfg_word;
   logic [W-1:0]  id_w [4];
   logic [4*W-1:0] id_words;
   logic          word_valid;
   logic [W-1:0]  word_data;
   logic          last;
   logic          busy, done, count_err;
   logic [15:0]   checksum;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit run_cmp = 1'b0;

   always #5 clk = ~clk;

   assign id_words = {id_w[3], id_w[2], id_w[1], id_w[0]};

   cks_accumulator u_cks_accumulator (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cfg_word   (cfg_word),
      .id_words   (id_words),
      .word_valid (word_valid),
      .word_data  (word_data),
      .last       (last),
      .busy       (busy),
      .done       (done),
      .checksum   (checksum),
      .count_err  (count_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit m_busy, m_done, m_err, m_prot;
   int m_cks, m_acc, m_cnt, m_cfgm, m_pid;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_err = 0; m_prot = 0;
         m_cks = 0; m_acc = 0; m_cnt = 0; m_cfgm = 0; m_pid = 0;
      end else begin
         m_done = 0;
         if (start) begin
            m_busy = 1; m_acc = 0; m_cnt = 0;
            m_prot = (cfg_word[13] == 1'b0);
            m_cfgm = int'(cfg_word) & 'h21FF;
            m_pid  = 0;
            for (int k = 0; k < 4; k++) m_pid = (m_pid << 4) | int'(id_w[k][3:0]);
         end else if (m_busy && word_valid) begin
            m_cnt++;
            if (!m_prot) m_acc = (m_acc + int'(word_data)) % 65536;
            if (last) begin
               m_busy = 0;
               m_done = 1;
               m_cks  = ((m_prot ? m_pid : m_acc) + m_cfgm) % 65536;
               m_err  = (m_cnt != N);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         chk("R10 busy vs model", 32'(busy), 32'(m_busy));
         chk("R6 done vs model", 32'(done), 32'(m_done));
         chk("R2 checksum vs model", 32'(checksum), 32'(m_cks));
         chk("R7 count_err vs model", 32'(count_err), 32'(m_err));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         total++;
         bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [W-1:0] wval(input int mode, input int i);
      case (mode)
         0:       return 14'h3FFF;
         1:       return W'(i);
         default: return W'((i * 37 + 5) & 'h3FFF);
      endcase
   endfunction

   // all tasks start and end just after a falling edge
   task automatic do_start(input logic [W-1:0] cfg, input bit junk_beat);
      start      = 1'b1;
      cfg_word   = cfg;
      word_valid = junk_beat;
      word_data  = 14'h1000;
      last       = junk_beat;
      @(negedge clk);
      start      = 1'b0;
      word_valid = 1'b0;
      last       = 1'b0;
   endtask

   task automatic send(input int n, input int mode, input int gap, input bit with_last);
      for (int i = 0; i < n; i++) begin
         if (gap != 0 && (i % gap) == 0) begin
            word_valid = 1'b0;
            word_data  = 14'h2AAA;
            last       = 1'b1;
            @(negedge clk);
         end
         word_valid = 1'b1;
         word_data  = wval(mode, i);
         last       = with_last && (i == n - 1);
         @(negedge clk);
      end
      word_valid = 1'b0;
      last       = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; cfg_word = '0; word_valid = 1'b0;
      word_data = '0; last = 1'b0;
      for (int k = 0; k < 4; k++) id_w[k] = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset busy", 32'(busy), 0);
      chk("R1 reset done", 32'(done), 0);
      chk("R1 reset checksum", 32'(checksum), 0);
      chk("R1 reset count_err", 32'(count_err), 0);
      rst_n = 1'b1;
      run_cmp = 1'b1;
      @(negedge clk);
      chk("R1 after reset checksum", 32'(checksum), 0);

      // blank unprotected image: wraps to 0x1DFF
      do_start(14'h3FFF, 1'b0);
      chk("R10 busy after start", 32'(busy), 1);
      send(N, 0, 0, 1'b1);
      chk("R5 blank checksum", 32'(checksum), 32'h1DFF);
      chk("R6 done after last", 32'(done), 1);
      chk("R7 exact count", 32'(count_err), 0);
      chk("R10 busy low with done", 32'(busy), 0);
      @(negedge clk);
      chk("R6 done single pulse", 32'(done), 0);
      chk("R6 checksum held", 32'(checksum), 32'h1DFF);

      // protected image: ID nibbles 1,2,3,4, noisy upper bits
      id_w[0] = 14'h3FF1; id_w[1] = 14'h2A42; id_w[2] = 14'h0003; id_w[3] = 14'h1234;
      do_start(14'h1FFF, 1'b0);
      id_w[0] = 14'h000F;
      send(N, 2, 7, 1'b1);
      chk("R3 R4 protected checksum", 32'(checksum), 32'h1433);
      chk("R7 protected count", 32'(count_err), 0);

      // beats outside a run are ignored
      send(5, 1, 0, 1'b1);
      chk("R9 idle beats no done", 32'(done), 0);
      chk("R9 idle beats checksum held", 32'(checksum), 32'h1433);

      // junk beat in start cycle, cfg changed after start
      do_start(14'h3FFF, 1'b1);
      cfg_word = 14'h0000;
      send(N, 1, 5, 1'b1);
      chk("R8 R9 ramp unprotected", 32'(checksum), 32'h1FFF);
      chk("R9 start-cycle beat not counted", 32'(count_err), 0);

      // restart mid-run
      do_start(14'h3FFF, 1'b0);
      send(5, 0, 0, 1'b0);
      do_start(14'h3FFF, 1'b0);
      send(N, 1, 0, 1'b1);
      chk("R8 restart clears sum", 32'(checksum), 32'h1FFF);
      chk("R8 restart clears count", 32'(count_err), 0);

      // one run too short, one too long
      do_start(14'h3FFF, 1'b0);
      send(10, 0, 0, 1'b1);
      chk("R7 short run error", 32'(count_err), 1);
      chk("R2 short run checksum", 32'(checksum), 32'hA1F5);
      do_start(14'h3FFF, 1'b0);
      send(N + 1, 0, 0, 1'b1);
      chk("R7 long run error", 32'(count_err), 1);
      chk("R5 long run checksum", 32'(checksum), 32'h5DFE);

      // exact run clears the error again
      do_start(14'h2ABC, 1'b0);
      send(N, 2, 0, 1'b1);
      chk("R7 error cleared", 32'(count_err), 0);
      chk("R6 done on final run", 32'(done), 1);

      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule